// File: doc/BRIEF.md
# Gate Drive Fault Shutdown Controller

This block sits between a three-phase PWM modulator and the six gate-drive pins of an inverter bridge. In normal running it passes the six modulator signals to the pins, each through its own programmable polarity. It also watches one external fault line. That line has a selectable active level. It is resynchronised through a two-flop chain and then qualified by a run-length filter. Once the line has been seen active for a programmable number of consecutive clocks, the fault is latched. All six pins are then driven to their off level, so both switches of every leg are open.

The latch holds the bridge off after the fault line returns to rest. It releases only when a clear strobe arrives while the synchronised fault line is inactive. A state machine with three states controls this:

- `ST_RUN`: outputs follow the modulator.
- `ST_TRIP`: latched, with the fault line still active.
- `ST_HOLD`: latched, with the fault line at rest and the block waiting for the clear.

The transitions are:

- `RUN->TRIP` on a qualified fault.
- `TRIP->HOLD` when the synchronised line goes inactive.
- `HOLD->TRIP` when the line becomes active again.
- `HOLD->RUN` on the clear strobe.

A clear while in `ST_TRIP` has no effect.

Top module: `gate_kill_top`

## Requirements
- R1: After reset, `fault_latched` is 0 and every `gate_out` bit follows its `pwm_in` bit under its polarity setting.
- R2: While not latched, `gate_out[i]` equals `pwm_in[i]` when `gate_pol_low[i]` is 0, and the inverse of `pwm_in[i]` when `gate_pol_low[i]` is 1. The output index order is bit 0 U high, 1 U low, 2 V high, 3 V low, 4 W high, 5 W low.
- R3: With `kill_pol_high` = 0, a low level on `kill_in` is a fault. With `kill_pol_high` = 1, a high level is a fault, and a steady low level causes no trip.
- R4: A fault pulse lasting FILT_CYCLES-1 clocks is ignored: `fault_latched` stays 0 and the outputs keep following `pwm_in`.
- R5: A fault pulse lasting exactly FILT_CYCLES clocks is recognised and latched.
- R6: Blanking takes effect on the (FILT_CYCLES+SYNC_STAGES)-th rising edge after the first edge that samples the fault. This sum must not exceed MAX_DELAY (100).
- R7: While latched, each `gate_out[i]` sits at its off level, which equals `gate_pol_low[i]`, whatever `pwm_in` does.
- R8: Once latched, the block stays latched after `kill_in` returns to rest, until `fault_clear` is asserted.
- R9: `fault_clear` has no effect while the synchronised fault line is still active.
- R10: `fault_clear` asserted while the fault line is at rest releases the latch at the next clock edge. The outputs then follow `pwm_in` again.
- R11: An active run broken by a single inactive clock restarts the qualification count. Two runs of FILT_CYCLES-1 clocks separated by a one-clock gap do not trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kill_in | input | 1 | Raw external fault line |
| kill_pol_high | input | 1 | 1: fault is active high; 0: fault is active low |
| gate_pol_low | input | 6 | Per-output polarity; 1 makes the pin low-true |
| pwm_in | input | 6 | High-true gate commands from the modulator |
| fault_clear | input | 1 | Clear strobe for the fault latch |
| gate_out | output | 6 | Gate-drive pins after polarity and blanking |
| fault_latched | output | 1 | 1 while the shutdown latch is set |

## Verification
The bench builds the block with FILT_CYCLES = 12 and the default two synchroniser stages. This gives a 14-clock blanking latency that can be checked edge by edge. The short window puts the exact-length pulse, the one-clock-short pulse and the restarted run within a few dozen cycles each. Both fault-line polarities and several mixed gate-polarity vectors are exercised. Because reset clears the fault latch, each polarity change is applied under reset.

// File: rtl/gk_pkg.sv
package gk_pkg;
    localparam int NUM_GATES = 6;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_TRIP = 2'd1,
        ST_HOLD = 2'd2
    } gk_state_t;
endpackage

// File: rtl/gk_sync.sv
module gk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_in};
        end
    end

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/gk_qualify.sv
module gk_qualify #(
    parameter int FILT_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic qualified
);
    localparam int CNT_W = $clog2(FILT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYCLES - 1);

    logic [CNT_W-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (!level) begin
            run_len <= '0;
        end else if (run_len != LAST) begin
            run_len <= run_len + 1'b1;
        end
    end

    assign qualified = level && (run_len == LAST);
endmodule

// File: rtl/gk_gate_drive.sv
module gk_gate_drive #(
    parameter int N = 6
) (
    input  logic [N-1:0] pwm,
    input  logic [N-1:0] pol_low,
    input  logic         blank,
    output logic [N-1:0] gate
);
    for (genvar g = 0; g < N; g++) begin : g_leg
        assign gate[g] = blank ? pol_low[g] : (pwm[g] ^ pol_low[g]);
    end
endmodule

// File: rtl/gate_kill_top.sv
module gate_kill_top
    import gk_pkg::*;
#(
    parameter int FILT_CYCLES = 32,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_DELAY   = 100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 kill_in,
    input  logic                 kill_pol_high,
    input  logic [NUM_GATES-1:0] gate_pol_low,
    input  logic [NUM_GATES-1:0] pwm_in,
    input  logic                 fault_clear,
    output logic [NUM_GATES-1:0] gate_out,
    output logic                 fault_latched
);
    gk_state_t state, state_nx;
    logic      kill_raw;
    logic      kill_sync;
    logic      kill_qual;
    logic      blank;

    assign kill_raw = kill_pol_high ? kill_in : ~kill_in;

    gk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (kill_raw),
        .q_out (kill_sync)
    );

    gk_qualify #(.FILT_CYCLES(FILT_CYCLES)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (kill_sync),
        .qualified (kill_qual)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (kill_qual) state_nx = ST_TRIP;
            ST_TRIP: if (!kill_sync) state_nx = ST_HOLD;
            ST_HOLD: begin
                if (kill_sync)        state_nx = ST_TRIP;
                else if (fault_clear) state_nx = ST_RUN;
            end
            default: state_nx = ST_TRIP;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_RUN:  blank = 1'b0;
            ST_TRIP: blank = 1'b1;
            ST_HOLD: blank = 1'b1;
            default: blank = 1'b1;
        endcase
    end

    assign fault_latched = blank;

    gk_gate_drive #(.N(NUM_GATES)) u_drive (
        .pwm     (pwm_in),
        .pol_low (gate_pol_low),
        .blank   (blank),
        .gate    (gate_out)
    );
endmodule

// File: rtl/gate_kill_chk.sv
module gate_kill_chk #(
    parameter int FILT_CYCLES = 32,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_DELAY   = 100
) (
    input logic       clk,
    input logic       rst_n,
    input logic       kill_sync,
    input logic       fault_clear,
    input logic [5:0] gate_pol_low,
    input logic [5:0] gate_out,
    input logic       fault_latched
);
    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] SAT = CW'(FILT_CYCLES);

    logic [CW-1:0] seen_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_run <= '0;
        end else if (!kill_sync) begin
            seen_run <= '0;
        end else if (seen_run != SAT) begin
            seen_run <= seen_run + 1'b1;
        end
    end

    // R6
    initial begin
        delay_budget_chk: assert (FILT_CYCLES + SYNC_STAGES <= MAX_DELAY && FILT_CYCLES >= 1);
    end

    // R7
    blank_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched |-> gate_out == gate_pol_low);

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched && !fault_clear |=> fault_latched);

    // R9
    clear_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched && kill_sync |=> fault_latched);

    // R10
    release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_latched) |-> $past(fault_clear));

    // R5
    trip_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_latched) |-> seen_run == SAT);
endmodule

bind gate_kill_top gate_kill_chk #(
    .FILT_CYCLES (FILT_CYCLES),
    .SYNC_STAGES (SYNC_STAGES),
    .MAX_DELAY   (MAX_DELAY)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .kill_sync     (kill_sync),
    .fault_clear   (fault_clear),
    .gate_pol_low  (gate_pol_low),
    .gate_out      (gate_out),
    .fault_latched (fault_latched)
);

// File: tb/gate_kill_top_bench.sv
module gate_kill_top_bench;
    localparam int F = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kill_in = 1'b1;
    logic       kill_pol_high = 1'b0;
    logic [5:0] gate_pol_low = '0;
    logic [5:0] pwm_in = '0;
    logic       fault_clear = 1'b0;
    logic [5:0] gate_out;
    logic       fault_latched;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    gate_kill_top #(.FILT_CYCLES(F)) u_gate_kill_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .kill_in       (kill_in),
        .kill_pol_high (kill_pol_high),
        .gate_pol_low  (gate_pol_low),
        .pwm_in        (pwm_in),
        .fault_clear   (fault_clear),
        .gate_out      (gate_out),
        .fault_latched (fault_latched)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic kpol, input logic [5:0] pol);
        @(negedge clk);
        rst_n = 1'b0;
        kill_pol_high = kpol;
        kill_in = ~kpol;
        gate_pol_low = pol;
        fault_clear = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic kill_on();
        kill_in = kill_pol_high;
    endtask

    task automatic kill_off();
        kill_in = ~kill_pol_high;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        fault_clear = 1'b1;
        @(negedge clk);
        fault_clear = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        do_reset(1'b0, 6'b000000);
        pwm_in = 6'b101010;
        #1;
        chk("R1 latched", {7'd0, fault_latched}, 8'd0);
        chk("R1 gate", {2'b0, gate_out}, {2'b0, 6'b101010});
    endtask

    task automatic t_polarity();
        gate_pol_low = 6'b110011;
        pwm_in = 6'b101010;
        #1;
        chk("R2 mix a", {2'b0, gate_out}, {2'b0, 6'b011001});
        pwm_in = 6'b010101;
        #1;
        chk("R2 mix b", {2'b0, gate_out}, {2'b0, 6'b100110});
    endtask

    task automatic t_short();
        do_reset(1'b0, 6'b000000);
        pwm_in = 6'b111111;
        kill_on();
        repeat (F - 1) @(negedge clk);
        kill_off();
        repeat (6) @(negedge clk);
        #1;
        chk("R4 latched", {7'd0, fault_latched}, 8'd0);
        chk("R4 gate", {2'b0, gate_out}, {2'b0, 6'b111111});
    endtask

    task automatic t_restart();
        do_reset(1'b0, 6'b000000);
        pwm_in = 6'b110110;
        kill_on();
        repeat (F - 1) @(negedge clk);
        kill_off();
        @(negedge clk);
        kill_on();
        repeat (F - 1) @(negedge clk);
        kill_off();
        repeat (6) @(negedge clk);
        #1;
        chk("R11 latched", {7'd0, fault_latched}, 8'd0);
        chk("R11 gate", {2'b0, gate_out}, {2'b0, 6'b110110});
    endtask

    task automatic t_exact();
        do_reset(1'b0, 6'b000000);
        pwm_in = 6'b111111;
        kill_on();
        repeat (F) @(negedge clk);
        kill_off();
        repeat (6) @(negedge clk);
        #1;
        chk("R5 latched", {7'd0, fault_latched}, 8'd1);
        chk("R5 gate", {2'b0, gate_out}, 8'd0);
    endtask

    task automatic t_latency_and_latch();
        do_reset(1'b0, 6'b000111);
        pwm_in = 6'b111111;
        #1;
        chk("R2 pre", {2'b0, gate_out}, {2'b0, 6'b111000});
        kill_on();
        repeat (F + 1) @(negedge clk);
        #1;
        chk("R6 early", {7'd0, fault_latched}, 8'd0);
        chk("R6 early gate", {2'b0, gate_out}, {2'b0, 6'b111000});
        @(negedge clk);
        #1;
        chk("R6 R3 on time", {7'd0, fault_latched}, 8'd1);
        chk("R7 level", {2'b0, gate_out}, {2'b0, 6'b000111});
        pwm_in = 6'b000000;
        #1;
        chk("R7 pwm zero", {2'b0, gate_out}, {2'b0, 6'b000111});
        pwm_in = 6'b101010;
        #1;
        chk("R7 pwm mix", {2'b0, gate_out}, {2'b0, 6'b000111});
        pulse_clear();
        chk("R9 clear ignored", {7'd0, fault_latched}, 8'd1);
        chk("R9 gate", {2'b0, gate_out}, {2'b0, 6'b000111});
        kill_off();
        repeat (6) @(negedge clk);
        #1;
        chk("R8 held", {7'd0, fault_latched}, 8'd1);
        chk("R8 gate", {2'b0, gate_out}, {2'b0, 6'b000111});
        pulse_clear();
        chk("R10 released", {7'd0, fault_latched}, 8'd0);
        chk("R10 gate", {2'b0, gate_out}, {2'b0, 6'b101101});
    endtask

    task automatic t_active_high();
        do_reset(1'b1, 6'b000000);
        pwm_in = 6'b101010;
        kill_in = 1'b0;
        repeat (F + 8) @(negedge clk);
        #1;
        chk("R3 low idle", {7'd0, fault_latched}, 8'd0);
        kill_in = 1'b1;
        repeat (F + 2) @(negedge clk);
        #1;
        chk("R3 high trips", {7'd0, fault_latched}, 8'd1);
        chk("R3 gate", {2'b0, gate_out}, 8'd0);
    endtask

    initial begin
        t_reset();
        t_polarity();
        t_short();
        t_restart();
        t_exact();
        t_latency_and_latch();
        t_active_high();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule